// File: doc/BRIEF.md
# Grouped Int8 Dot-Product Accumulator

This unit treats each source operand as a row of four-element groups of signed 8-bit values. For every group it forms the four element-wise products with the matching group of the second operand, adds them, and folds the result into that group's own 32-bit accumulator. A job is launched with a valid/ready handshake. The launch carries the vector length `vl`, counted in 8-bit elements, the two packed sources and the starting accumulators. The unit then walks through one group per clock and pulses `done` when the last group has been written.

The unit accepts a job only when `vl` covers whole groups and fits within the operand width. Any other length is refused: `illegal` is raised with `done`, and every accumulator is returned exactly as it was supplied. A length of zero is legal and finishes at once. Groups that lie past `vl/4` are never written.

Control is a three-state machine. `ST_IDLE` waits for a launch. A legal non-empty launch moves it to `ST_RUN`. A zero-length launch or a refused launch moves it straight to `ST_DONE`. `ST_RUN` adds one group per clock and moves to `ST_DONE` after the last counted group. `ST_DONE` holds for one cycle and then returns to `ST_IDLE`.

Top module: `eg_dot_acc`

## Requirements
- R1: After reset, `start_ready` is 1, `done` and `illegal` are 0, and `acc_out` is all zeros.
- R2: A job is taken on a clock edge where both `start_valid` and `start_ready` are 1. `start_ready` stays 0 from the taking edge until the unit is back in idle. Inputs presented while the unit is busy have no effect.
- R3: Element j of group i sits at bits [(4i+j)*8 +: 8] of `src_a` and `src_b`. Accumulator i sits at bits [32i +: 32] of `acc_in` and `acc_out`. For each counted group, the final accumulator equals its starting value plus the sum over j=0..3 of a[4i+j]*b[4i+j], with every element signed two's complement.
- R4: Products are sign-extended to 32 bits, and the accumulation wraps modulo 2^32.
- R5: For a legal `vl` = 4n, `done` is high in the n+1-th cycle after the taking edge and lasts one cycle. `start_ready` is 1 in the cycle that follows.
- R6: Accumulators of groups with index at or above `vl/4` end the job equal to their `acc_in` value.
- R7: If `vl` is not a multiple of 4, `done` and `illegal` are both 1 in the cycle after the taking edge, and `acc_out` equals `acc_in` in full.
- R8: If `vl` exceeds four times the group count (16 by default), the job is refused in the same way as in R7.
- R9: `vl` = 0 is legal. `done` is 1 and `illegal` is 0 in the cycle after the taking edge, and no accumulator changes.
- R10: While idle with no launch, `acc_out` holds the last job's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Launch request |
| start_ready | output | 1 | Unit is idle and will take a launch |
| vl | input | VL_W (5) | Vector length in 8-bit elements |
| src_a | input | NUM_GROUPS*32 (128) | Packed first source elements |
| src_b | input | NUM_GROUPS*32 (128) | Packed second source elements |
| acc_in | input | NUM_GROUPS*32 (128) | Starting accumulators |
| acc_out | output | NUM_GROUPS*32 (128) | Current accumulators |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Job refused, valid with done |

## Verification
The bound checker holds the following on every cycle:
- An unaligned, oversize or zero length produces its one-cycle completion in the next cycle.
- A refused job returns the accumulators it was handed.
- `done` is a single pulse followed by ready, and `illegal` never appears without `done`.
- The accumulators stay still while the unit idles.

Only the bench scenarios show the rest:
- The arithmetic of each group, including sign handling and wrap-around.
- The n+1-cycle latency for a given length.
- That groups beyond the length keep their values.
- That inputs changed during a busy job leave its result untouched.

// File: rtl/eg_dot_pkg.sv
package eg_dot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } eg_state_t;

endpackage

// File: rtl/eg_dot_lane.sv
// Signed dot product of one group, sign-extended to the accumulator width.
module eg_dot_lane #(
    parameter int GRP_ELEMS = 4,
    parameter int ELEM_W    = 8,
    parameter int ACC_W     = 32
) (
    input  logic [GRP_ELEMS*ELEM_W-1:0] grp_a,
    input  logic [GRP_ELEMS*ELEM_W-1:0] grp_b,
    output logic [ACC_W-1:0]            grp_sum
);
    localparam int PROD_W = 2 * ELEM_W;

    logic signed [PROD_W-1:0] prod [GRP_ELEMS];

    for (genvar j = 0; j < GRP_ELEMS; j++) begin : g_mul
        logic signed [ELEM_W-1:0] ea;
        logic signed [ELEM_W-1:0] eb;
        assign ea = grp_a[j*ELEM_W +: ELEM_W];
        assign eb = grp_b[j*ELEM_W +: ELEM_W];
        assign prod[j] = ea * eb;
    end

    always_comb begin
        grp_sum = '0;
        for (int j = 0; j < GRP_ELEMS; j++) begin
            grp_sum = grp_sum + {{(ACC_W-PROD_W){prod[j][PROD_W-1]}}, prod[j]};
        end
    end
endmodule

// File: rtl/eg_dot_fsm.sv
// Launch decode, group sequencing and completion signalling.
module eg_dot_fsm
    import eg_dot_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_ELEMS  = 4,
    parameter int VL_W       = 5,
    parameter int IDX_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    input  logic [VL_W-1:0]  vl,
    output logic             start_ready,
    output logic             run_en,
    output logic [IDX_W-1:0] grp_idx,
    output logic             done,
    output logic             illegal
);
    localparam int GRP_SHIFT = $clog2(GRP_ELEMS);
    localparam int MAX_VL    = NUM_GROUPS * GRP_ELEMS;

    eg_state_t        state_q, state_d;
    logic [IDX_W-1:0] grp_q, last_q;
    logic             bad_q;

    logic             accept;
    logic             vl_bad;
    logic [VL_W-1:0]  ngrp;

    assign accept = start_valid && (state_q == ST_IDLE);
    assign vl_bad = (vl[GRP_SHIFT-1:0] != '0) || (vl > VL_W'(MAX_VL));
    assign ngrp   = vl >> GRP_SHIFT;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_valid) state_d = (vl_bad || ngrp == '0) ? ST_DONE : ST_RUN;
            ST_RUN:  if (grp_q == last_q) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grp_q   <= '0;
            last_q  <= '0;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                grp_q  <= '0;
                last_q <= IDX_W'(ngrp - VL_W'(1));
                bad_q  <= vl_bad;
            end else if (state_q == ST_RUN) begin
                grp_q <= grp_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        start_ready = 1'b0;
        run_en      = 1'b0;
        done        = 1'b0;
        illegal     = 1'b0;
        unique case (state_q)
            ST_IDLE: start_ready = 1'b1;
            ST_RUN:  run_en      = 1'b1;
            ST_DONE: begin
                done    = 1'b1;
                illegal = bad_q;
            end
            default: ;
        endcase
    end

    assign grp_idx = grp_q;
endmodule

// File: rtl/eg_dot_acc.sv
// Top: operand capture, shared lane, and the accumulator bank.
module eg_dot_acc #(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_ELEMS  = 4,
    parameter int ELEM_W     = 8,
    parameter int ACC_W      = 32,
    localparam int GRP_W     = GRP_ELEMS * ELEM_W,
    localparam int VEC_W     = NUM_GROUPS * GRP_W,
    localparam int ACC_BUS_W = NUM_GROUPS * ACC_W,
    localparam int VL_W      = $clog2(NUM_GROUPS * GRP_ELEMS + 1),
    localparam int IDX_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_valid,
    output logic                 start_ready,
    input  logic [VL_W-1:0]      vl,
    input  logic [VEC_W-1:0]     src_a,
    input  logic [VEC_W-1:0]     src_b,
    input  logic [ACC_BUS_W-1:0] acc_in,
    output logic [ACC_BUS_W-1:0] acc_out,
    output logic                 done,
    output logic                 illegal
);
    logic             run_en;
    logic [IDX_W-1:0] grp_idx;
    logic             accept;
    logic [VEC_W-1:0] a_q, b_q;
    logic [GRP_W-1:0] a_sel, b_sel;
    logic [ACC_W-1:0] lane_sum;
    logic [ACC_W-1:0] acc_q [NUM_GROUPS];

    eg_dot_fsm #(
        .NUM_GROUPS(NUM_GROUPS),
        .GRP_ELEMS (GRP_ELEMS),
        .VL_W      (VL_W),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_valid(start_valid),
        .vl         (vl),
        .start_ready(start_ready),
        .run_en     (run_en),
        .grp_idx    (grp_idx),
        .done       (done),
        .illegal    (illegal)
    );

    assign accept = start_valid && start_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (accept) begin
            a_q <= src_a;
            b_q <= src_b;
        end
    end

    assign a_sel = a_q[grp_idx*GRP_W +: GRP_W];
    assign b_sel = b_q[grp_idx*GRP_W +: GRP_W];

    eg_dot_lane #(
        .GRP_ELEMS(GRP_ELEMS),
        .ELEM_W   (ELEM_W),
        .ACC_W    (ACC_W)
    ) u_lane (
        .grp_a  (a_sel),
        .grp_b  (b_sel),
        .grp_sum(lane_sum)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_acc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[g] <= '0;
            end else if (accept) begin
                acc_q[g] <= acc_in[g*ACC_W +: ACC_W];
            end else if (run_en && grp_idx == IDX_W'(g)) begin
                acc_q[g] <= acc_q[g] + lane_sum;
            end
        end
        assign acc_out[g*ACC_W +: ACC_W] = acc_q[g];
    end
endmodule

// File: rtl/eg_dot_acc_chk.sv
module eg_dot_acc_chk #(
    parameter int VL_W      = 5,
    parameter int ACC_BUS_W = 128,
    parameter int MAX_VL    = 16,
    parameter int GRP_ELEMS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_valid,
    input logic                 start_ready,
    input logic [VL_W-1:0]      vl,
    input logic [ACC_BUS_W-1:0] acc_in,
    input logic [ACC_BUS_W-1:0] acc_out,
    input logic                 done,
    input logic                 illegal
);
    logic take;
    logic misal;
    logic oversize;

    assign take     = start_valid && start_ready;
    assign misal    = (vl % VL_W'(GRP_ELEMS)) != '0;
    assign oversize = vl > VL_W'(MAX_VL);

    AST_MISALIGNED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        take && misal |=> done && illegal); // R7
    AST_OVERSIZE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        take && oversize |=> done && illegal); // R8
    AST_REFUSED_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        take && (misal || oversize) |=> acc_out == $past(acc_in)); // R7
    AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        take && vl == '0 |=> done && !illegal && acc_out == $past(acc_in)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && start_ready); // R5
    AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !start_ready); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready && !start_valid |=> $stable(acc_out)); // R10
endmodule

bind eg_dot_acc eg_dot_acc_chk #(
    .VL_W     (VL_W),
    .ACC_BUS_W(ACC_BUS_W),
    .MAX_VL   (NUM_GROUPS * GRP_ELEMS),
    .GRP_ELEMS(GRP_ELEMS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_valid(start_valid),
    .start_ready(start_ready),
    .vl         (vl),
    .acc_in     (acc_in),
    .acc_out    (acc_out),
    .done       (done),
    .illegal    (illegal)
);

// File: tb/eg_dot_acc_tb_top.sv
`timescale 1ns/1ps
module eg_dot_acc_tb_top;
    localparam int NG    = 4;
    localparam int VEC_W = NG * 32;
    localparam int ACC_W = NG * 32;
    localparam int VL_W  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_valid = 1'b0;
    logic             start_ready;
    logic [VL_W-1:0]  vl = '0;
    logic [VEC_W-1:0] src_a = '0, src_b = '0;
    logic [ACC_W-1:0] acc_in = '0;
    logic [ACC_W-1:0] acc_out;
    logic             done, illegal;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    eg_dot_acc dut_i (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .vl(vl), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .acc_out(acc_out), .done(done), .illegal(illegal)
    );

    function automatic logic [31:0] grp_dot(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b, input int g);
        int s = 0;
        for (int j = 0; j < 4; j++) begin
            s += int'($signed(a[(4*g+j)*8 +: 8])) * int'($signed(b[(4*g+j)*8 +: 8]));
        end
        return 32'(s);
    endfunction

    task automatic check(input string req, input string what, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, stepped on each rising edge
    int               m_state = 0;
    int               m_grp = 0, m_ngrp = 0;
    bit               m_bad = 0;
    logic [31:0]      m_acc [NG];
    logic [VEC_W-1:0] m_a, m_b;
    string            cur_req = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0;
            for (int g = 0; g < NG; g++) m_acc[g] <= '0;
        end else begin
            case (m_state)
                0: if (start_valid) begin
                    m_a    <= src_a;
                    m_b    <= src_b;
                    m_grp  <= 0;
                    m_ngrp <= int'(vl) / 4;
                    m_bad  <= (int'(vl) % 4 != 0) || (int'(vl) > 4 * NG);
                    for (int g = 0; g < NG; g++) m_acc[g] <= acc_in[g*32 +: 32];
                    m_state <= ((int'(vl) % 4 != 0) || (int'(vl) > 4 * NG) || int'(vl) < 4) ? 2 : 1;
                end
                1: begin
                    m_acc[m_grp] <= m_acc[m_grp] + grp_dot(m_a, m_b, m_grp);
                    m_grp <= m_grp + 1;
                    if (m_grp + 1 == m_ngrp) m_state <= 2;
                end
                default: m_state <= 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [ACC_W-1:0] exp_acc;
            for (int g = 0; g < NG; g++) exp_acc[g*32 +: 32] = m_acc[g];
            check({cur_req, "/R2"}, "start_ready", ACC_W'(start_ready), ACC_W'(m_state == 0));
            check({cur_req, "/R5"}, "done", ACC_W'(done), ACC_W'(m_state == 2));
            check({cur_req, "/R7"}, "illegal", ACC_W'(illegal), ACC_W'(m_state == 2 && m_bad));
            check({cur_req, "/R3"}, "acc_out", acc_out, exp_acc);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<50000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [VEC_W-1:0] rnd_vec();
        logic [VEC_W-1:0] v;
        for (int k = 0; k < VEC_W / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // Launch a job and return at the negedge of its done cycle.
    task automatic run_job(input logic [VL_W-1:0] v, input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                           input logic [ACC_W-1:0] acc, input bit junk, output int lat);
        @(negedge clk);
        start_valid = 1'b1; vl = v; src_a = a; src_b = b; acc_in = acc;
        while (!start_ready) @(negedge clk);
        @(negedge clk);
        if (junk) begin
            vl = 5'd5; src_a = rnd_vec(); src_b = rnd_vec(); acc_in = rnd_vec();
        end else begin
            start_valid = 1'b0;
        end
        lat = 0;
        while (!done) begin
            lat++;
            @(negedge clk);
        end
        start_valid = 1'b0;
    endtask

    initial begin
        logic [VEC_W-1:0] a, b;
        logic [ACC_W-1:0] acc, exp;
        logic [ACC_W-1:0] hold;
        int lat;

        repeat (3) @(negedge clk);
        check("R1", "reset ready", ACC_W'(start_ready), ACC_W'(1));
        check("R1", "reset done/illegal", ACC_W'({done, illegal}), '0);
        check("R1", "reset acc_out", acc_out, '0);
        rst_n = 1'b1;

        // R3: full length, random data
        cur_req = "R3";
        a = rnd_vec(); b = rnd_vec(); acc = rnd_vec();
        run_job(5'd16, a, b, acc, 1'b0, lat);
        for (int g = 0; g < NG; g++) exp[g*32 +: 32] = acc[g*32 +: 32] + grp_dot(a, b, g);
        check("R3", "full dot", acc_out, exp);
        check("R5", "latency vl=16", ACC_W'(lat), ACC_W'(4));

        // R4: wrap around, (-128)*(-128)*4 = 65536 added to 0xFFFF0000
        cur_req = "R4";
        a = '0; b = '0; a[31:0] = 32'h80808080; b[31:0] = 32'h80808080;
        acc = rnd_vec(); acc[31:0] = 32'hFFFF_0000;
        run_job(5'd4, a, b, acc, 1'b0, lat);
        check("R4", "wrap to zero", ACC_W'(acc_out[31:0]), '0);
        // mixed signs: 127*-128 + -1*-1 + 0 + 5*3 = -16256+1+15 = -16240
        a[31:0] = {8'd5, 8'd0, 8'hFF, 8'd127}; b[31:0] = {8'd3, 8'd9, 8'hFF, 8'h80};
        acc[31:0] = 32'd0;
        run_job(5'd4, a, b, acc, 1'b0, lat);
        check("R4", "signed mix", ACC_W'(acc_out[31:0]), ACC_W'(32'hFFFF_C090));

        // R5 + R6: partial length
        cur_req = "R6";
        a = rnd_vec(); b = rnd_vec(); acc = rnd_vec();
        run_job(5'd8, a, b, acc, 1'b0, lat);
        check("R5", "latency vl=8", ACC_W'(lat), ACC_W'(2));
        check("R6", "groups 2..3 kept", ACC_W'(acc_out[127:64]), ACC_W'(acc[127:64]));
        run_job(5'd4, a, b, acc, 1'b0, lat);
        check("R6", "groups 1..3 kept", ACC_W'(acc_out[127:32]), ACC_W'(acc[127:32]));

        // R7: misaligned
        cur_req = "R7";
        acc = rnd_vec();
        run_job(5'd6, rnd_vec(), rnd_vec(), acc, 1'b0, lat);
        check("R7", "illegal flag", ACC_W'(illegal), ACC_W'(1));
        check("R7", "acc unchanged", acc_out, acc);
        check("R7", "latency", ACC_W'(lat), '0);

        // R8: oversize
        cur_req = "R8";
        acc = rnd_vec();
        run_job(5'd20, rnd_vec(), rnd_vec(), acc, 1'b0, lat);
        check("R8", "illegal flag", ACC_W'(illegal), ACC_W'(1));
        check("R8", "acc unchanged", acc_out, acc);

        // R9: zero length
        cur_req = "R9";
        acc = rnd_vec();
        run_job(5'd0, rnd_vec(), rnd_vec(), acc, 1'b0, lat);
        check("R9", "no illegal", ACC_W'(illegal), '0);
        check("R9", "latency", ACC_W'(lat), '0);
        check("R9", "acc unchanged", acc_out, acc);

        // R2: inputs changing while busy are ignored
        cur_req = "R2";
        a = rnd_vec(); b = rnd_vec(); acc = rnd_vec();
        run_job(5'd12, a, b, acc, 1'b1, lat);
        for (int g = 0; g < NG; g++) exp[g*32 +: 32] = (g < 3) ? acc[g*32 +: 32] + grp_dot(a, b, g) : acc[g*32 +: 32];
        check("R2", "busy inputs ignored", acc_out, exp);

        // R10: idle hold with changing data and valid low
        cur_req = "R10";
        @(negedge clk);
        hold = acc_out;
        for (int k = 0; k < 6; k++) begin
            vl = 5'($urandom); src_a = rnd_vec(); acc_in = rnd_vec();
            @(negedge clk);
        end
        check("R10", "idle hold", acc_out, hold);

        // more random legal jobs against the model
        cur_req = "R3";
        for (int k = 0; k < 20; k++) begin
            run_job(5'(4 * ($urandom % 5)), rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, lat);
        end

        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule